// File: doc/BRIEF.md
# Memory-protection entry register bank

This block holds the software-visible state of sixteen memory-protection entries. Each entry has an 8-bit configuration byte and an address register. Software reaches them through a single CSR write port and a separate CSR read port, both addressed by a 12-bit CSR number. The configuration CSRs pack several entry bytes into one machine word, so one write can update many entries at once. The address CSRs map one-to-one onto entries.

Every write passes through a lock filter. A configuration byte whose lock bit is set keeps its old value, while the other bytes in the same word update normally. An address write is dropped when its own entry is locked. The data width XLEN is a parameter that takes the value 32 or 64. With XLEN = 64, an accepted address write keeps only the low 54 bits and zero-fills the rest.

All entries are also exported as flat vectors to a neighbouring access checker. The read port is combinational and returns the stored, post-filter values, so a rejected write can be confirmed from outside the block.

Top module: `pmp_csr_bank`

## Requirements
- R1: After a synchronous active-low reset, every configuration byte and every address register reads as zero and is exported as zero.
- R2: Configuration CSRs start at 0x3A0 and place the lowest entry in bits 7:0. With XLEN = 32, CSRs 0x3A0 to 0x3A3 each hold four entries (CSR 0x3A0+k holds entries 4k to 4k+3). With XLEN = 64, 0x3A0 holds entries 0 to 7 and 0x3A2 holds entries 8 to 15, eight bytes each.
- R3: Bit 7 of a configuration byte is its lock bit. A write leaves a locked byte unchanged, including its lock bit. Unlocked bytes in the same CSR word take the written data in the same cycle. A write that sets the lock bit on an unlocked byte is stored.
- R4: Address CSR 0x3B0+i holds the address of entry i (i = 0 to 15). An accepted write is visible on the read port in the cycle after the write edge.
- R5: A write to address CSR 0x3B0+i is ignored when bit 7 of entry i's configuration byte is set. Address CSRs of unlocked entries still accept writes.
- R6: With XLEN = 64, an accepted address write stores data bits 53:0 and zeros in bits 63:54. With XLEN = 32, the full 32-bit word is stored.
- R7: With XLEN = 64, configuration CSRs 0x3A1 and 0x3A3 read as zero, and writes to them change no entry.
- R8: Byte i of `cfg_out` (bits 8i+7:8i) equals entry i's configuration byte. Slice i of `addr_out` (bits XLEN·i+XLEN-1:XLEN·i) equals entry i's address register.
- R9: A CSR number outside the configuration and address ranges reads as zero, and a write to it changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CSR write strobe |
| wr_csr | input | 12 | CSR number of the write |
| wr_data | input | XLEN | Write data |
| rd_csr | input | 12 | CSR number of the read |
| rd_data | output | XLEN | Combinational read data |
| cfg_out | output | 128 | All sixteen configuration bytes, entry i in byte i |
| addr_out | output | 16·XLEN | All sixteen address registers, entry i in slice i |

## Verification
The hardest case to reach is a single configuration write that lands on a word where some bytes are locked and others are not. Only the filtered mix of old and new bytes shows whether the lock is applied per byte rather than per word. The stimulus first writes a word that sets the lock bit on one entry. It then writes new data to the whole word, and later writes all zeros to try to clear the lock. After each write it reads the word back and checks the exported byte. The same locked entry is then targeted with an address write next to an unlocked neighbour, to show that the lock reaches only its own entry's address register.

// File: rtl/pmp_bank_pkg.sv
// Package: shared constants and types for the protection-entry register bank.
// Assumes a fixed space of sixteen entries, as given by the CSR numbering.
package pmp_bank_pkg;
    localparam int          NENT          = 16;
    localparam logic [11:0] CFG_CSR_BASE  = 12'h3A0;
    localparam logic [11:0] ADDR_CSR_BASE = 12'h3B0;
    localparam int          LOCK_BIT      = 7;
    localparam int          WIDE_ADDR_KEEP = 54;

    typedef logic [7:0] cfg_byte_t;

    // Returns the lock flag held in a configuration byte.
    function automatic logic is_locked(input cfg_byte_t b);
        return b[LOCK_BIT];
    endfunction
endpackage

// File: rtl/pmp_csr_decode.sv
// Module: decodes a 12-bit CSR number into configuration-word and address hits.
// Assumes XLEN is 32 or 64; on 64 only even configuration indices exist.
module pmp_csr_decode
    import pmp_bank_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [11:0] csr,
    output logic        cfg_hit,
    output logic [1:0]  cfg_grp,
    output logic        addr_hit,
    output logic [3:0]  addr_idx
);
    localparam int STRIDE = XLEN / 32;

    logic cfg_range;

    // Classifies the CSR number into one of the two register ranges.
    always_comb begin
        cfg_range = (csr[11:2] == CFG_CSR_BASE[11:2]);
        addr_hit  = (csr[11:4] == ADDR_CSR_BASE[11:4]);
        addr_idx  = csr[3:0];
    end

    generate
        if (STRIDE == 1) begin : g_narrow
            assign cfg_hit = cfg_range;
            assign cfg_grp = csr[1:0];
        end else begin : g_wide
            assign cfg_hit = cfg_range && !csr[0];
            assign cfg_grp = {1'b0, csr[1]};
        end
    endgenerate
endmodule

// File: rtl/pmp_cfg_entry.sv
// Module: one configuration byte with lock filtering on write.
// Assumes the lock bit position from the package; reset clears the byte.
module pmp_cfg_entry
    import pmp_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  cfg_byte_t wdata,
    output cfg_byte_t cfg_q
);
    // Holds the byte; a locked byte ignores writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (we && !is_locked(cfg_q))
            cfg_q <= wdata;
    end

    // R3
    locked_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_locked(cfg_q) |=> $stable(cfg_q));
endmodule

// File: rtl/pmp_addr_entry.sv
// Module: one address register, gated by its entry's lock and width-trimmed.
// Assumes XLEN is 32 or 64; on 64 only the low WIDE_ADDR_KEEP bits are kept.
module pmp_addr_entry
    import pmp_bank_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            locked,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] addr_q
);
    localparam int KEEP = (XLEN > WIDE_ADDR_KEEP) ? WIDE_ADDR_KEEP : XLEN;

    logic [XLEN-1:0] trimmed;

    // Zero-extends the kept low bits of the write data.
    always_comb begin
        trimmed = '0;
        trimmed[KEEP-1:0] = wdata[KEEP-1:0];
    end

    // Holds the address; dropped while the owning entry is locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (we && !locked)
            addr_q <= trimmed;
    end

    // R5
    locked_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(addr_q));

    generate
        if (KEEP < XLEN) begin : g_upper
            // R6
            addr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                addr_q[XLEN-1:KEEP] == '0);
        end
    endgenerate
endmodule

// File: rtl/pmp_csr_bank.sv
// Module: top of the protection-entry register bank. Decodes the CSR write
// and read ports, steers bytes to the entries and exports all entry state.
// Assumes CSR privilege checks happen upstream; the read port is combinational.
module pmp_csr_bank
    import pmp_bank_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [11:0]          wr_csr,
    input  logic [XLEN-1:0]      wr_data,
    input  logic [11:0]          rd_csr,
    output logic [XLEN-1:0]      rd_data,
    output logic [NENT*8-1:0]    cfg_out,
    output logic [NENT*XLEN-1:0] addr_out
);
    localparam int BYTES = XLEN / 8;

    logic       w_cfg_hit, w_addr_hit, r_cfg_hit, r_addr_hit;
    logic [1:0] w_grp, r_grp;
    logic [3:0] w_idx, r_idx;

    cfg_byte_t       cfg_q  [NENT];
    logic [XLEN-1:0] addr_q [NENT];

    pmp_csr_decode #(.XLEN(XLEN)) u_wdec (
        .csr(wr_csr), .cfg_hit(w_cfg_hit), .cfg_grp(w_grp),
        .addr_hit(w_addr_hit), .addr_idx(w_idx));

    pmp_csr_decode #(.XLEN(XLEN)) u_rdec (
        .csr(rd_csr), .cfg_hit(r_cfg_hit), .cfg_grp(r_grp),
        .addr_hit(r_addr_hit), .addr_idx(r_idx));

    genvar i;
    generate
        for (i = 0; i < NENT; i++) begin : g_ent
            logic cfg_we, addr_we;
            assign cfg_we  = wr_en && w_cfg_hit && (int'(w_grp) == i / BYTES);
            assign addr_we = wr_en && w_addr_hit && (int'(w_idx) == i);

            pmp_cfg_entry u_cfg (
                .clk(clk), .rst_n(rst_n), .we(cfg_we),
                .wdata(wr_data[8*(i%BYTES) +: 8]), .cfg_q(cfg_q[i]));

            pmp_addr_entry #(.XLEN(XLEN)) u_addr (
                .clk(clk), .rst_n(rst_n), .we(addr_we),
                .locked(is_locked(cfg_q[i])), .wdata(wr_data), .addr_q(addr_q[i]));

            assign cfg_out[8*i +: 8]        = cfg_q[i];
            assign addr_out[XLEN*i +: XLEN] = addr_q[i];
        end
    endgenerate

    // Selects the packed configuration word or one address for the read port.
    always_comb begin
        rd_data = '0;
        if (r_cfg_hit) begin
            for (int e = 0; e < NENT; e++)
                if (e / BYTES == int'(r_grp))
                    rd_data[8*(e%BYTES) +: 8] = cfg_q[e];
        end else if (r_addr_hit) begin
            for (int e = 0; e < NENT; e++)
                if (int'(r_idx) == e)
                    rd_data = addr_q[e];
        end
    end

    generate
        if (XLEN == 64) begin : g_odd_chk
            // R7
            odd_cfg_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_csr[11:2] == CFG_CSR_BASE[11:2] && rd_csr[0]) |-> (rd_data == '0));
        end
    endgenerate

    // R9
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_csr[11:4] != 8'h3A && rd_csr[11:4] != 8'h3B) |-> (rd_data == '0));
endmodule

// File: tb/tb_pmp_csr_bank.sv
`timescale 1ns/1ps
// Bench: scoreboard for the register bank. Driver tasks push expected items,
// a monitor pops and compares them at the falling edge.
module tb_pmp_csr_bank;
    localparam int XLEN = 64;
    localparam int NENT = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [11:0]          wr_csr = '0;
    logic [XLEN-1:0]      wr_data = '0;
    logic [11:0]          rd_csr = '0;
    logic [XLEN-1:0]      rd_data;
    logic [NENT*8-1:0]    cfg_out;
    logic [NENT*XLEN-1:0] addr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int              kind;   // 0 read port, 1 cfg export byte, 2 addr export slice
        int              idx;
        logic [XLEN-1:0] exp;
        string           tag;
    } item_t;
    item_t sb[$];

    pmp_csr_bank #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_csr(wr_csr),
        .wr_data(wr_data), .rd_csr(rd_csr), .rd_data(rd_data),
        .cfg_out(cfg_out), .addr_out(addr_out));

    always #2.5 clk = ~clk;

    // Monitor: compares all pending items at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [XLEN-1:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = rd_data;
                    1:       act = {{(XLEN-8){1'b0}}, cfg_out[8*it.idx +: 8]};
                    default: act = addr_out[XLEN*it.idx +: XLEN];
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic do_write(input logic [11:0] csr, input logic [XLEN-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_csr = csr; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic exp_read(input logic [11:0] csr, input logic [XLEN-1:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        rd_csr = csr;
        it.kind = 0; it.idx = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_port(input int kind, input int idx, input logic [XLEN-1:0] e, input string tag);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        exp_read(12'h3A0, '0, "R1 cfg word 0");
        exp_read(12'h3A2, '0, "R1 cfg word 2");
        exp_read(12'h3B5, '0, "R1 addr 5");
        exp_port(2, 15, '0, "R1 addr export 15");

        // R2 packing, R8 export
        do_write(12'h3A0, 64'h0F0E_0D0C_0B0A_0908);
        exp_read(12'h3A0, 64'h0F0E_0D0C_0B0A_0908, "R2 cfg word 0");
        exp_port(1, 3, 64'h0B, "R8 cfg export entry 3");
        do_write(12'h3A2, 64'h1716_1514_1312_1110);
        exp_read(12'h3A2, 64'h1716_1514_1312_1110, "R2 cfg word 2");
        exp_port(1, 8, 64'h10, "R8 cfg export entry 8");
        exp_port(1, 15, 64'h17, "R8 cfg export entry 15");

        // R6 truncation, R4 mapping
        do_write(12'h3B3, 64'hFFFF_FFFF_FFFF_FFFF);
        exp_read(12'h3B3, 64'h003F_FFFF_FFFF_FFFF, "R6 addr 3 trimmed");
        exp_port(2, 3, 64'h003F_FFFF_FFFF_FFFF, "R8 addr export 3");
        do_write(12'h3B4, 64'h0000_1234_5678_9ABC);
        exp_read(12'h3B4, 64'h0000_1234_5678_9ABC, "R4 addr 4");
        exp_read(12'h3B3, 64'h003F_FFFF_FFFF_FFFF, "R4 addr 3 untouched");

        // R3 lock entry 3, then partial update
        do_write(12'h3A0, 64'h0F0E_0D0C_8B0A_0908);
        exp_read(12'h3A0, 64'h0F0E_0D0C_8B0A_0908, "R3 lock set stored");
        do_write(12'h3A0, 64'h2726_2524_2322_2120);
        exp_read(12'h3A0, 64'h2726_2524_8B22_2120, "R3 locked byte kept");
        do_write(12'h3A0, 64'h0);
        exp_read(12'h3A0, 64'h0000_0000_8B00_0000, "R3 lock not clearable");
        exp_port(1, 3, 64'h8B, "R3 cfg export entry 3");

        // R5 address lock only on its own entry
        do_write(12'h3B3, 64'h5);
        exp_read(12'h3B3, 64'h003F_FFFF_FFFF_FFFF, "R5 locked addr kept");
        do_write(12'h3B4, 64'h77);
        exp_read(12'h3B4, 64'h77, "R5 neighbour addr written");

        // R7 odd configuration indices
        do_write(12'h3A1, 64'hFFFF_FFFF_FFFF_FFFF);
        exp_read(12'h3A1, '0, "R7 cfg 0x3A1 zero");
        exp_read(12'h3A0, 64'h0000_0000_8B00_0000, "R7 cfg word 0 unchanged");
        exp_read(12'h3A2, 64'h1716_1514_1312_1110, "R7 cfg word 2 unchanged");
        do_write(12'h3A3, 64'hFFFF_FFFF_FFFF_FFFF);
        exp_read(12'h3A3, '0, "R7 cfg 0x3A3 zero");
        exp_read(12'h3A2, 64'h1716_1514_1312_1110, "R7 cfg word 2 after 0x3A3");

        // R9 unmapped CSR
        do_write(12'h3C0, 64'hFFFF_FFFF_FFFF_FFFF);
        exp_read(12'h3C0, '0, "R9 unmapped reads zero");
        exp_read(12'h3B0, '0, "R9 addr 0 unchanged");
        exp_read(12'h3A0, 64'h0000_0000_8B00_0000, "R9 cfg word 0 unchanged");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule